// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a 16-bit parallel flash array. It sees one synchronous write cycle per clock (address, data and a write strobe) and walks an unlock-guarded sequence to decide what the host asked for. A fixed two-write key must come before every command. Program then takes one further write that carries the target word. Any erase repeats the key and finishes with a selector write, so an erase takes six writes in all. When a sequence completes, the block raises a one-cycle start pulse. Along with the pulse it presents the operation kind, the address and data of the final write, and the index of the erase region. The program/erase engine and the array are outside this block.

The decoder also holds the read mode, which is one of array, identification or query table. In identification mode it supplies the manufacturer and device words on a separate read address port. While the status logic reports an internal operation as busy, the decoder ignores every write. Any write that does not fit the expected step ends the sequence and returns the read mode to array.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, mode_o is 0 (array), start_o is 0, and the decoder waits for the first key write.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by one more write at any address start a word program. On the clock edge that takes the fourth write, start_o rises for one cycle with op_o = 0 (program), tgt_addr_o and tgt_data_o equal to that fourth write's address and data, and erase_unit_o = 0.
- R3: In command writes, only address bits 14..0 and data bits 7..0 are compared. Higher bits do not affect decoding.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h start a chip erase: start_o pulses with op_o = 1 and erase_unit_o = 0. If 10h is written to any other address in the sixth write, no erase starts.
- R5: The same five writes followed by 30h at any address start a sector erase: op_o = 2 and erase_unit_o = address bits 19..11 of the sixth write.
- R6: The same five writes followed by 50h at any address start a block erase: op_o = 3 and erase_unit_o = address bits 19..15 of the sixth write, zero-extended.
- R7: A write that does not fit the current step cancels the sequence and sets mode_o to 0. A later sequence must then begin again from the first key write.
- R8: While busy_i is 1, every write is ignored. This includes the exit command. The sequence step, the mode and the start pulse are all left unchanged.
- R9: Key plus 90h@5555h sets mode_o to 1 (identification). In that mode, id_data_o is 00BFh when rd_addr is 0 and 2782h when rd_addr is 1, and 0 for any other address. Outside mode 1, id_data_o is always 0.
- R10: Key plus 98h@5555h sets mode_o to 2 (query table).
- R11: A write of F0h sets mode_o to 0. This works at any address, either alone or as the third write after the key.
- R12: start_o is never high for two cycles in a row. Whenever it is high, the mode is array and the decoder is back at its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | A write cycle is presented this clock |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy_i | input | 1 | An internal program or erase is running |
| rd_addr | input | 20 | Read address used for identification words |
| start_o | output | 1 | One-cycle pulse that launches an operation |
| op_o | output | 2 | 0 program, 1 chip erase, 2 sector erase, 3 block erase |
| tgt_addr_o | output | 20 | Address of the write that completed the sequence |
| tgt_data_o | output | 16 | Data of the write that completed the sequence |
| erase_unit_o | output | 9 | Sector or block index of the erase |
| mode_o | output | 2 | 0 array, 1 identification, 2 query table |
| id_data_o | output | 16 | Identification word for rd_addr |

## Verification
A write the bench presents is taken on the next rising edge. The mode, the start pulse and the latched target fields all come from registers loaded on that edge, so every result is due one cycle after its write. start_o must drop again one cycle later. The bench drives each write at a falling edge, waits for the rising edge, and checks the outputs at the following falling edge; it then checks start_o again one falling edge later. id_data_o is combinational from rd_addr and the mode register, so it is checked shortly after rd_addr changes, within the same cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KEY1  = 3'd1,
    ST_KEY2  = 3'd2,
    ST_WORD  = 3'd3,
    ST_EKEY0 = 3'd4,
    ST_EKEY1 = 3'd5,
    ST_ESEL  = 3'd6
  } step_t;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_IDENT = 2'd1,
    MD_QUERY = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_CHIP  = 2'd1,
    OP_SECT  = 2'd2,
    OP_BLOCK = 2'd3
  } op_t;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_QUERY   = 8'h98;
  localparam logic [7:0] CODE_LEAVE   = 8'hF0;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_BLOCK   = 8'h50;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [CMP_W-1:0] cmd_addr,
  input  logic [7:0]       cmd_byte,
  output logic             at_key_a,
  output logic             hit_key_a,
  output logic             hit_key_b,
  output logic             is_leave
);

  logic at_key_b;

  always_comb begin
    at_key_a  = (cmd_addr == KEY_ADDR_A);
    at_key_b  = (cmd_addr == KEY_ADDR_B);
    hit_key_a = at_key_a && (cmd_byte == CODE_KEY_A);
    hit_key_b = at_key_b && (cmd_byte == CODE_KEY_B);
    is_leave  = (cmd_byte == CODE_LEAVE);
  end

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       busy_i,
  input  logic       at_key_a,
  input  logic       hit_key_a,
  input  logic       hit_key_b,
  input  logic       is_leave,
  input  logic [7:0] cmd_byte,
  output step_t      step_q,
  output mode_t      mode_q,
  output logic       fire,
  output op_t        fire_op
);

  step_t step_d;
  mode_t mode_d;
  logic  accept;

  assign accept = wr_en && !busy_i;

  always_comb begin
    step_d  = step_q;
    mode_d  = mode_q;
    fire    = 1'b0;
    fire_op = OP_PROG;
    if (accept) begin
      step_d = ST_IDLE;
      case (step_q)
        ST_IDLE: begin
          if (hit_key_a) step_d = ST_KEY1;
          else           mode_d = MD_ARRAY;
        end
        ST_KEY1: begin
          if (hit_key_b) step_d = ST_KEY2;
          else           mode_d = MD_ARRAY;
        end
        ST_KEY2: begin
          mode_d = MD_ARRAY;
          if (at_key_a) begin
            case (cmd_byte)
              CODE_PROG:  begin step_d = ST_WORD;  mode_d = mode_q; end
              CODE_ERASE: begin step_d = ST_EKEY0; mode_d = mode_q; end
              CODE_IDENT: mode_d = MD_IDENT;
              CODE_QUERY: mode_d = MD_QUERY;
              default:    mode_d = MD_ARRAY;
            endcase
          end
        end
        ST_WORD: begin
          fire    = 1'b1;
          fire_op = OP_PROG;
          mode_d  = MD_ARRAY;
        end
        ST_EKEY0: begin
          if (hit_key_a) step_d = ST_EKEY1;
          else           mode_d = MD_ARRAY;
        end
        ST_EKEY1: begin
          if (hit_key_b) step_d = ST_ESEL;
          else           mode_d = MD_ARRAY;
        end
        ST_ESEL: begin
          mode_d = MD_ARRAY;
          if (cmd_byte == CODE_CHIP && at_key_a) begin
            fire    = 1'b1;
            fire_op = OP_CHIP;
          end else if (cmd_byte == CODE_SECTOR) begin
            fire    = 1'b1;
            fire_op = OP_SECT;
          end else if (cmd_byte == CODE_BLOCK) begin
            fire    = 1'b1;
            fire_op = OP_BLOCK;
          end
        end
        default: mode_d = MD_ARRAY;
      endcase
      if (is_leave && step_q != ST_WORD) begin
        step_d = ST_IDLE;
        mode_d = MD_ARRAY;
        fire   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      mode_q <= MD_ARRAY;
    end else if (accept) begin
      step_q <= step_d;
      mode_q <= mode_d;
    end
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(step_q) && $stable(mode_q))); // R8

endmodule

// File: rtl/op_latch.sv
module op_latch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  localparam int UNIT_W  = ADDR_W - SECT_LSB,
  localparam int PAD_W   = BLK_LSB - SECT_LSB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              fire,
  input  op_t               fire_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              start_q,
  output op_t               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [UNIT_W-1:0] unit_q
);

  logic [UNIT_W-1:0] unit_d;

  always_comb begin
    case (fire_op)
      OP_SECT:  unit_d = wr_addr[ADDR_W-1:SECT_LSB];
      OP_BLOCK: unit_d = {{PAD_W{1'b0}}, wr_addr[ADDR_W-1:BLK_LSB]};
      default:  unit_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      unit_q <= '0;
    end else if (fire) begin
      op_q   <= fire_op;
      addr_q <= wr_addr;
      data_q <= wr_data;
      unit_q <= unit_d;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R12

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !start_q); // R8

endmodule

// File: rtl/ident_rom.sv
module ident_rom
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter int          DATA_W = 16,
  parameter logic [15:0] MFR_ID = 16'h00BF,
  parameter logic [15:0] DEV_ID = 16'h2782
)(
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] id_data
);

  logic low_pair;

  always_comb begin
    low_pair = (rd_addr[ADDR_W-1:1] == '0);
    id_data  = '0;
    if (mode == MD_IDENT && low_pair)
      id_data = rd_addr[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  localparam int UNIT_W  = ADDR_W - SECT_LSB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              start_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic [UNIT_W-1:0] erase_unit_o,
  output logic [1:0]        mode_o,
  output logic [DATA_W-1:0] id_data_o
);

  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       at_key_a, hit_key_a, hit_key_b, is_leave;
  logic       fire;
  op_t        fire_op;
  op_t        op_q;
  step_t      step_q;
  mode_t      mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  cmd_match u_match (
    .cmd_addr  (wr_addr[CMP_W-1:0]),
    .cmd_byte  (wr_data[7:0]),
    .at_key_a  (at_key_a),
    .hit_key_a (hit_key_a),
    .hit_key_b (hit_key_b),
    .is_leave  (is_leave)
  );

  cmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .busy_i    (busy_i),
    .at_key_a  (at_key_a),
    .hit_key_a (hit_key_a),
    .hit_key_b (hit_key_b),
    .is_leave  (is_leave),
    .cmd_byte  (wr_data[7:0]),
    .step_q    (step_q),
    .mode_q    (mode_q),
    .fire      (fire),
    .fire_op   (fire_op)
  );

  op_latch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .busy_i  (busy_i),
    .fire    (fire),
    .fire_op (fire_op),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .start_q (start_o),
    .op_q    (op_q),
    .addr_q  (tgt_addr_o),
    .data_q  (tgt_data_o),
    .unit_q  (erase_unit_o)
  );

  ident_rom #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rom (
    .mode    (mode_q),
    .rd_addr (rd_addr),
    .id_data (id_data_o)
  );

  assign op_o   = op_q;
  assign mode_o = mode_q;

  AST_LAUNCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_o |-> (step_q == ST_IDLE && mode_q == MD_ARRAY)); // R12

  AST_SEQ_RESET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && !busy_i && is_leave && step_q != ST_WORD) |=> (mode_q == MD_ARRAY)); // R11

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;
  logic        busy_i;
  logic [19:0] rd_addr;
  logic        start_o;
  logic [1:0]  op_o;
  logic [19:0] tgt_addr_o;
  logic [15:0] tgt_data_o;
  logic [8:0]  erase_unit_o;
  logic [1:0]  mode_o;
  logic [15:0] id_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .rd_addr(rd_addr),
    .start_o(start_o), .op_o(op_o), .tgt_addr_o(tgt_addr_o),
    .tgt_data_o(tgt_data_o), .erase_unit_o(erase_unit_o),
    .mode_o(mode_o), .id_data_o(id_data_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic key();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic erase_head();
    key();
    wr(20'h05555, 16'h0080);
    key();
  endtask

  task automatic t_reset();
    chk("R1", "mode after reset", mode_o, 0);
    chk("R1", "start after reset", start_o, 0);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h00100, 16'h1111);
    chk("R1", "no start without key", start_o, 0);
  endtask

  task automatic t_program();
    key();
    wr(20'h05555, 16'h00A0);
    chk("R2", "no start before word", start_o, 0);
    wr(20'hABCDE, 16'h1234);
    chk("R2", "start pulse", start_o, 1);
    chk("R2", "op program", op_o, 0);
    chk("R2", "target addr", tgt_addr_o, 20'hABCDE);
    chk("R2", "target data", tgt_data_o, 16'h1234);
    chk("R2", "unit zero", erase_unit_o, 0);
    @(negedge clk);
    chk("R12", "pulse one cycle", start_o, 0);
  endtask

  task automatic t_mask();
    wr(20'hF5555, 16'hFFAA);
    wr(20'h32AAA, 16'h7755);
    wr(20'h85555, 16'h12A0);
    wr(20'h00010, 16'h5A5A);
    chk("R3", "high bits ignored start", start_o, 1);
    chk("R3", "target data", tgt_data_o, 16'h5A5A);
    @(negedge clk);
  endtask

  task automatic t_chip();
    erase_head();
    wr(20'h05555, 16'h0010);
    chk("R4", "chip start", start_o, 1);
    chk("R4", "chip op", op_o, 1);
    chk("R4", "chip unit", erase_unit_o, 0);
    @(negedge clk);
    erase_head();
    wr(20'h01234, 16'h0010);
    chk("R4", "chip at wrong address", start_o, 0);
    chk("R7", "mode after bad chip", mode_o, 0);
  endtask

  task automatic t_sector();
    erase_head();
    wr(20'hABCDE, 16'h0030);
    chk("R5", "sector start", start_o, 1);
    chk("R5", "sector op", op_o, 2);
    chk("R5", "sector index", erase_unit_o, 9'h157);
    @(negedge clk);
  endtask

  task automatic t_block();
    erase_head();
    wr(20'hABCDE, 16'h0050);
    chk("R6", "block start", start_o, 1);
    chk("R6", "block op", op_o, 3);
    chk("R6", "block index", erase_unit_o, 9'h015);
    @(negedge clk);
  endtask

  task automatic t_abort();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAB, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h00200, 16'h2222);
    chk("R7", "bad key cancels", start_o, 0);
    key();
    wr(20'h05555, 16'h0090);
    chk("R9", "ident entry", mode_o, 1);
    wr(20'h00000, 16'h1234);
    chk("R7", "stray write leaves ident", mode_o, 0);
  endtask

  task automatic t_ident();
    key();
    wr(20'h05555, 16'h0090);
    chk("R9", "mode ident", mode_o, 1);
    rd_addr = 20'h00000; #1;
    chk("R9", "maker word", id_data_o, 16'h00BF);
    rd_addr = 20'h00001; #1;
    chk("R9", "device word", id_data_o, 16'h2782);
    rd_addr = 20'h80001; #1;
    chk("R9", "other address", id_data_o, 0);
    wr(20'h12345, 16'h00F0);
    chk("R11", "F0 anywhere exits", mode_o, 0);
    rd_addr = 20'h00000; #1;
    chk("R9", "no id in array", id_data_o, 0);
  endtask

  task automatic t_query();
    key();
    wr(20'h05555, 16'h0098);
    chk("R10", "mode query", mode_o, 2);
    key();
    chk("R10", "mode kept during key", mode_o, 2);
    wr(20'h05555, 16'h00F0);
    chk("R11", "three-write exit", mode_o, 0);
  endtask

  task automatic t_busy();
    key();
    wr(20'h05555, 16'h0090);
    busy_i = 1'b1;
    wr(20'h00000, 16'h00F0);
    chk("R8", "F0 ignored while busy", mode_o, 1);
    busy_i = 1'b0;
    wr(20'h05555, 16'h00AA);
    busy_i = 1'b1;
    wr(20'h00777, 16'h0001);
    wr(20'h00778, 16'h0002);
    busy_i = 1'b0;
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    busy_i = 1'b1;
    wr(20'h00300, 16'h3333);
    chk("R8", "no start while busy", start_o, 0);
    busy_i = 1'b0;
    wr(20'h00400, 16'h4444);
    chk("R8", "step held over busy", start_o, 1);
    chk("R8", "word after busy", tgt_data_o, 16'h4444);
    chk("R12", "mode array at start", mode_o, 0);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    busy_i  = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_mask();
    t_chip();
    t_sector();
    t_block();
    t_abort();
    t_ident();
    t_query();
    t_busy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule